// File: doc/BRIEF.md
# Task-Graph Instance Dispatcher

This block hands work from a small task dependency graph to a pool of identical cores. Software writes one entry per task through a single-cycle configuration port: a predecessor mask, a loop-back mask, a kind bit (single-shot or replicated) and an instance count. Once the enable pin is high, the block pairs every idle core with the next unallocated instance of the lowest-numbered ready task. It can fill every idle core in the same cycle. A core learns which task and which instance number it must run. Each core reports back with a completion message that carries a one-bit result.

For every task the block keeps how many instances it has allocated and how many have completed. When the completed count reaches the total, the task is marked done and its done bit opens the gate for its successors. A task whose loop-back mask is non-zero acts as a loop controller. If it finishes with result 0, it re-arms itself and the masked tasks by clearing their done flags and both counters. If it finishes with result 1, it is marked done in the normal way.

Each core has its own pair of valid/ready streams. The dispatch stream holds an offer (task, instance) stable until the core accepts it; a core that does not raise `disp_ready` just delays its own work. The completion stream is accepted only while that core is running an accepted instance, which `cpl_ready` shows.

Top module: `task_dispatch_sched`

## Requirements
- R1: After reset no dispatch offer is valid, `task_done` is all zero and `cpl_ready` is all zero.
- R2: A configuration write stores a task's predecessor mask, loop-back mask, kind and count. A single-shot task (`cfg_dup`=0) runs exactly once, as instance 0, whatever `cfg_count` holds.
- R3: A task is dispatched only when it has been configured, is not done and every task in its predecessor mask is done. Nothing is dispatched while `sched_en` is low.
- R4: In each cycle the idle cores, taken in ascending index order, each receive the next unallocated instance of the lowest-numbered ready task that still has unallocated instances. Several cores can be served in one cycle.
- R5: A replicated task with count N dispatches instance numbers 0 to N-1, each exactly once per round, in ascending order.
- R6: An offer on core c (`disp_valid[c]`=1) keeps its task and instance fields stable until `disp_ready[c]` is seen high at a clock edge. After that the core is busy.
- R7: A task becomes done only when its completed count equals its total. No successor is offered before the last instance of every predecessor has completed.
- R8: A task with a non-zero loop-back mask whose final completion carries result 0 clears done, allocated and completed state for itself and every masked task, so they run again. With result 1 it is marked done.
- R9: `cpl_ready[c]` is high exactly while core c holds an accepted instance. A completion is counted only then.
- R10: `task_done` bit t reflects the done state of task t, with task t on bit t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sched_en | input | 1 | Allows allocation of instances to cores |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_task | input | 4 | Task slot being written |
| cfg_pred | input | 16 | Predecessor mask, bit p = depends on task p |
| cfg_loop | input | 16 | Loop-back mask, re-armed on result 0 |
| cfg_dup | input | 1 | 1 = replicated task, 0 = single-shot |
| cfg_count | input | 16 | Instance count for a replicated task |
| disp_valid | output | 8 | Per-core offer valid |
| disp_ready | input | 8 | Per-core offer accept |
| disp_task | output | 32 | Per-core task id, core c at bits [4c+3:4c] |
| disp_inst | output | 128 | Per-core instance number, core c at bits [16c+15:16c] |
| cpl_valid | input | 8 | Per-core completion valid |
| cpl_result | input | 8 | Per-core one-bit result of the finished instance |
| cpl_ready | output | 8 | Per-core completion accept (core busy) |
| task_done | output | 16 | Done flag per task |

## Verification
Two events can land in the same cycle: the final completion of a task, and the allocation step that fills cores freed in earlier cycles. The done bit is registered, so a successor must first appear in the cycle after the last completion edge. The bench provokes this with the 100-instance fork/join graph. Eight cores run with staggered accept stalls and run times, so completions and new allocations overlap all the time. The bench checks at the moment each end-task or controller offer appears that its predecessors' completions have all been counted. In the loop graph, a controller's result-0 completion coincides with the re-arm. The bench judges it by the re-run instance numbers restarting at 0 and the total dispatch counts per task.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // Per-core slot state: idle, offering an instance, running it
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_OFFER = 2'd1,
    SLOT_BUSY  = 2'd2
  } slot_state_e;

endpackage

// File: rtl/sched_task_table.sv
module sched_task_table #(
  parameter int NT    = 16,
  parameter int NC    = 8,
  parameter int CNT_W = 16,
  localparam int TID_W = $clog2(NT),
  localparam int IW    = $clog2(NC + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [TID_W-1:0]           cfg_id,
  input  logic [NT-1:0]              cfg_pred,
  input  logic [NT-1:0]              cfg_loop,
  input  logic                       cfg_dup,
  input  logic [CNT_W-1:0]           cfg_count,
  input  logic [NT-1:0][IW-1:0]      alloc_inc,
  input  logic [NT-1:0][IW-1:0]      cpl_inc,
  input  logic [NT-1:0]              cpl_hi,
  output logic [NT-1:0]              ready,
  output logic [NT-1:0][CNT_W-1:0]   alloc_cnt,
  output logic [NT-1:0][CNT_W-1:0]   total,
  output logic [NT-1:0]              done
);

  logic [NT-1:0]             loaded_q;
  logic [NT-1:0][NT-1:0]     pred_q;
  logic [NT-1:0][NT-1:0]     loop_q;
  logic [NT-1:0][CNT_W-1:0]  total_q;
  logic [NT-1:0][CNT_W-1:0]  alloc_q;
  logic [NT-1:0][CNT_W-1:0]  cmpl_q;
  logic [NT-1:0]             done_q;

  logic [NT-1:0][CNT_W-1:0]  cmpl_nxt;
  logic [NT-1:0]             fin;
  logic [NT-1:0]             loopback;
  logic [NT-1:0]             set_vec;
  logic [NT-1:0]             clr_vec;

  // Completion arithmetic and loop-back decision
  always_comb begin
    clr_vec = '0;
    for (int t = 0; t < NT; t++) begin
      cmpl_nxt[t] = cmpl_q[t] + CNT_W'(cpl_inc[t]);
      fin[t]      = (cpl_inc[t] != '0) && (cmpl_nxt[t] == total_q[t]);
      loopback[t] = fin[t] && !cpl_hi[t] && (loop_q[t] != '0);
      set_vec[t]  = fin[t] && !loopback[t];
      if (loopback[t]) begin
        clr_vec = clr_vec | loop_q[t] | (NT'(1) << t);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
      pred_q   <= '0;
      loop_q   <= '0;
      total_q  <= '0;
      alloc_q  <= '0;
      cmpl_q   <= '0;
      done_q   <= '0;
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (cfg_we && (cfg_id == TID_W'(t))) begin
          loaded_q[t] <= 1'b1;
          pred_q[t]   <= cfg_pred;
          loop_q[t]   <= cfg_loop;
          total_q[t]  <= cfg_dup ? cfg_count : CNT_W'(1);
          alloc_q[t]  <= '0;
          cmpl_q[t]   <= '0;
          done_q[t]   <= 1'b0;
        end else if (clr_vec[t]) begin
          alloc_q[t]  <= '0;
          cmpl_q[t]   <= '0;
          done_q[t]   <= 1'b0;
        end else begin
          alloc_q[t]  <= alloc_q[t] + CNT_W'(alloc_inc[t]);
          cmpl_q[t]   <= cmpl_nxt[t];
          if (set_vec[t]) begin
            done_q[t] <= 1'b1;
          end
        end
      end
    end
  end

  // Readiness: configured, not done, all predecessors done
  always_comb begin
    for (int t = 0; t < NT; t++) begin
      ready[t] = loaded_q[t] && !done_q[t] && ((pred_q[t] & ~done_q) == '0);
    end
  end

  assign alloc_cnt = alloc_q;
  assign total     = total_q;
  assign done      = done_q;

  generate
    for (genvar g = 0; g < NT; g++) begin : g_chk
      AST_ALLOC_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_q[g] <= total_q[g]); // R5
      AST_CMPL_LE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_q[g] <= alloc_q[g]); // R7
      AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        done_q[g] |-> (cmpl_q[g] == total_q[g])); // R7
      AST_LOOP_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback[g] && !cfg_we) |=> (!done_q[g] && (cmpl_q[g] == '0))); // R8
    end
  endgenerate

endmodule

// File: rtl/sched_alloc.sv
module sched_alloc #(
  parameter int NT    = 16,
  parameter int NC    = 8,
  parameter int CNT_W = 16,
  localparam int TID_W = $clog2(NT),
  localparam int IW    = $clog2(NC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [NC-1:0]             idle,
  input  logic [NT-1:0]             ready,
  input  logic [NT-1:0][CNT_W-1:0]  alloc_cnt,
  input  logic [NT-1:0][CNT_W-1:0]  total,
  output logic [NC-1:0]             grant,
  output logic [NC-1:0][TID_W-1:0]  grant_task,
  output logic [NC-1:0][CNT_W-1:0]  grant_inst,
  output logic [NT-1:0][IW-1:0]     alloc_inc
);

  logic [NT-1:0][CNT_W-1:0] tmp;
  logic                     found;

  // Cores in ascending order each take the lowest ready task with room left
  always_comb begin
    tmp        = alloc_cnt;
    alloc_inc  = '0;
    grant      = '0;
    grant_task = '0;
    grant_inst = '0;
    found      = 1'b0;
    for (int c = 0; c < NC; c++) begin
      found = 1'b0;
      if (en && idle[c]) begin
        for (int t = 0; t < NT; t++) begin
          if (!found && ready[t] && (tmp[t] < total[t])) begin
            found         = 1'b1;
            grant[c]      = 1'b1;
            grant_task[c] = TID_W'(t);
            grant_inst[c] = tmp[t];
            tmp[t]        = tmp[t] + CNT_W'(1);
            alloc_inc[t]  = alloc_inc[t] + IW'(1);
          end
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NC; g++) begin : g_chk
      AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        grant[g] |-> (ready[grant_task[g]] && en && idle[g])); // R3
      AST_GRANT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        grant[g] |-> (grant_inst[g] < total[grant_task[g]])); // R5
    end
  endgenerate

endmodule

// File: rtl/sched_core_slot.sv
module sched_core_slot
  import sched_pkg::*;
#(
  parameter int TID_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic [TID_W-1:0] grant_task,
  input  logic [CNT_W-1:0] grant_inst,
  output logic             idle,
  output logic             disp_valid,
  input  logic             disp_ready,
  output logic [TID_W-1:0] disp_task,
  output logic [CNT_W-1:0] disp_inst,
  input  logic             cpl_valid,
  output logic             cpl_ready,
  output logic             cpl_fire,
  output logic [TID_W-1:0] cpl_task
);

  slot_state_e      st_q;
  logic [TID_W-1:0] task_q;
  logic [CNT_W-1:0] inst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SLOT_IDLE;
      task_q <= '0;
      inst_q <= '0;
    end else begin
      unique case (st_q)
        SLOT_IDLE: begin
          if (grant) begin
            st_q   <= SLOT_OFFER;
            task_q <= grant_task;
            inst_q <= grant_inst;
          end
        end
        SLOT_OFFER: begin
          if (disp_ready) begin
            st_q <= SLOT_BUSY;
          end
        end
        SLOT_BUSY: begin
          if (cpl_valid) begin
            st_q <= SLOT_IDLE;
          end
        end
        default: st_q <= SLOT_IDLE;
      endcase
    end
  end

  assign idle       = (st_q == SLOT_IDLE);
  assign disp_valid = (st_q == SLOT_OFFER);
  assign disp_task  = task_q;
  assign disp_inst  = inst_q;
  assign cpl_ready  = (st_q == SLOT_BUSY);
  assign cpl_fire   = cpl_ready && cpl_valid;
  assign cpl_task   = task_q;

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_task) && $stable(disp_inst))); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> (cpl_ready && !disp_valid)); // R6
  AST_CPL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_fire |=> (!cpl_ready)); // R9

endmodule

// File: rtl/task_dispatch_sched.sv
module task_dispatch_sched #(
  parameter int NT    = 16,
  parameter int NC    = 8,
  parameter int CNT_W = 16,
  localparam int TID_W = $clog2(NT),
  localparam int IW    = $clog2(NC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sched_en,
  input  logic                  cfg_we,
  input  logic [TID_W-1:0]      cfg_task,
  input  logic [NT-1:0]         cfg_pred,
  input  logic [NT-1:0]         cfg_loop,
  input  logic                  cfg_dup,
  input  logic [CNT_W-1:0]      cfg_count,
  output logic [NC-1:0]         disp_valid,
  input  logic [NC-1:0]         disp_ready,
  output logic [NC*TID_W-1:0]   disp_task,
  output logic [NC*CNT_W-1:0]   disp_inst,
  input  logic [NC-1:0]         cpl_valid,
  input  logic [NC-1:0]         cpl_result,
  output logic [NC-1:0]         cpl_ready,
  output logic [NT-1:0]         task_done
);

  logic [NT-1:0]             ready;
  logic [NT-1:0][CNT_W-1:0]  alloc_cnt;
  logic [NT-1:0][CNT_W-1:0]  total;
  logic [NT-1:0][IW-1:0]     alloc_inc;
  logic [NT-1:0][IW-1:0]     cpl_inc;
  logic [NT-1:0]             cpl_hi;
  logic [NC-1:0]             idle;
  logic [NC-1:0]             grant;
  logic [NC-1:0][TID_W-1:0]  grant_task;
  logic [NC-1:0][CNT_W-1:0]  grant_inst;
  logic [NC-1:0]             cpl_fire;
  logic [NC-1:0][TID_W-1:0]  cpl_task;
  logic [NC-1:0][TID_W-1:0]  slot_task;
  logic [NC-1:0][CNT_W-1:0]  slot_inst;

  sched_task_table #(.NT(NT), .NC(NC), .CNT_W(CNT_W)) u_tasks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_id    (cfg_task),
    .cfg_pred  (cfg_pred),
    .cfg_loop  (cfg_loop),
    .cfg_dup   (cfg_dup),
    .cfg_count (cfg_count),
    .alloc_inc (alloc_inc),
    .cpl_inc   (cpl_inc),
    .cpl_hi    (cpl_hi),
    .ready     (ready),
    .alloc_cnt (alloc_cnt),
    .total     (total),
    .done      (task_done)
  );

  sched_alloc #(.NT(NT), .NC(NC), .CNT_W(CNT_W)) u_alloc (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (sched_en),
    .idle       (idle),
    .ready      (ready),
    .alloc_cnt  (alloc_cnt),
    .total      (total),
    .grant      (grant),
    .grant_task (grant_task),
    .grant_inst (grant_inst),
    .alloc_inc  (alloc_inc)
  );

  generate
    for (genvar c = 0; c < NC; c++) begin : g_core
      sched_core_slot #(.TID_W(TID_W), .CNT_W(CNT_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (grant[c]),
        .grant_task (grant_task[c]),
        .grant_inst (grant_inst[c]),
        .idle       (idle[c]),
        .disp_valid (disp_valid[c]),
        .disp_ready (disp_ready[c]),
        .disp_task  (slot_task[c]),
        .disp_inst  (slot_inst[c]),
        .cpl_valid  (cpl_valid[c]),
        .cpl_ready  (cpl_ready[c]),
        .cpl_fire   (cpl_fire[c]),
        .cpl_task   (cpl_task[c])
      );
      assign disp_task[c*TID_W +: TID_W] = slot_task[c];
      assign disp_inst[c*CNT_W +: CNT_W] = slot_inst[c];
    end
  endgenerate

  // Gather accepted completions per task
  always_comb begin
    cpl_inc = '0;
    cpl_hi  = '0;
    for (int t = 0; t < NT; t++) begin
      for (int c = 0; c < NC; c++) begin
        if (cpl_fire[c] && (cpl_task[c] == TID_W'(t))) begin
          cpl_inc[t] = cpl_inc[t] + IW'(1);
          if (cpl_result[c]) begin
            cpl_hi[t] = 1'b1;
          end
        end
      end
    end
  end

  AST_NO_OFFER_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sched_en && (disp_valid == '0)) |=> (disp_valid == '0)); // R3

endmodule

// File: tb/task_dispatch_sched_tb.sv
`timescale 1ns/1ps
module task_dispatch_sched_tb;
  localparam int NT = 16;
  localparam int NC = 8;
  localparam int CW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sched_en = 1'b0;
  logic cfg_we = 1'b0;
  logic [TW-1:0] cfg_task = '0;
  logic [NT-1:0] cfg_pred = '0;
  logic [NT-1:0] cfg_loop = '0;
  logic cfg_dup = 1'b0;
  logic [CW-1:0] cfg_count = '0;
  logic [NC-1:0] disp_valid;
  logic [NC-1:0] disp_ready = '0;
  logic [NC*TW-1:0] disp_task;
  logic [NC*CW-1:0] disp_inst;
  logic [NC-1:0] cpl_valid = '0;
  logic [NC-1:0] cpl_result = '0;
  logic [NC-1:0] cpl_ready;
  logic [NT-1:0] task_done;

  always #4 clk = ~clk;

  task_dispatch_sched u_dut (
    .clk(clk), .rst_n(rst_n), .sched_en(sched_en),
    .cfg_we(cfg_we), .cfg_task(cfg_task), .cfg_pred(cfg_pred), .cfg_loop(cfg_loop),
    .cfg_dup(cfg_dup), .cfg_count(cfg_count),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_task(disp_task), .disp_inst(disp_inst),
    .cpl_valid(cpl_valid), .cpl_result(cpl_result), .cpl_ready(cpl_ready), .task_done(task_done)
  );

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 0;
  bit model_on = 0;
  int scen = 0;
  int rec_n = 0;
  int phase [NC];
  int cnt [NC];
  int ctask [NC];
  int cinst [NC];
  int disp_count [NT];
  int cpl_count [NT];
  int seen [128];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bookkeeping for every new offer, with scenario-specific expectations
  task automatic record(input int c);
    int t;
    int i;
    t = ctask[c];
    i = cinst[c];
    if (scen == 1) begin
      if (t == 0) chk(i == 0, "R2 single-shot instance", i, 0);
      if (t == 1) begin
        chk(cpl_count[0] == 1, "R3 fork waits for start", cpl_count[0], 1);
        chk(i == disp_count[1], "R4 ascending instance order", i, disp_count[1]);
        if (i >= 0 && i < 128) seen[i]++;
      end
      if (t == 2) chk(cpl_count[1] == 100, "R7 join after all instances", cpl_count[1], 100);
    end else if (scen == 2) begin
      if (t == 1) begin
        chk(i == disp_count[1] % 5, "R5 per-round instance order", i, disp_count[1] % 5);
        if (i >= 0 && i < 128) seen[i]++;
      end
      if (t == 2) chk(cpl_count[1] == 5 * (disp_count[2] + 1), "R7 controller after round",
                      cpl_count[1], 5 * (disp_count[2] + 1));
      if (t == 3) chk(cpl_count[2] == 3, "R8 exit after result 1", cpl_count[2], 3);
    end else if (scen == 3) begin
      if (rec_n < 8) begin
        chk(c == rec_n, "R4 core order", c, rec_n);
        chk(t == ((rec_n < 4) ? 1 : 2), "R4 lowest task first", t, (rec_n < 4) ? 1 : 2);
        chk(i == rec_n % 4, "R4 instance per core", i, rec_n % 4);
      end
    end
    disp_count[t]++;
    rec_n++;
  endtask

  // Emulated cores: accept with per-core stall, run, then report
  always @(negedge clk) begin
    if (!model_on) begin
      for (int c = 0; c < NC; c++) begin
        phase[c] = 0;
        cnt[c] = 0;
      end
      disp_ready = '0;
      cpl_valid = '0;
      cpl_result = '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        if (phase[c] == 0) begin
          if (disp_valid[c]) begin
            ctask[c] = int'(disp_task[c*TW +: TW]);
            cinst[c] = int'(disp_inst[c*CW +: CW]);
            record(c);
            if (c % 3 == 0) begin
              disp_ready[c] = 1'b1;
              phase[c] = 2;
              cnt[c] = 1 + (cinst[c] + c) % 4;
            end else begin
              phase[c] = 1;
              cnt[c] = c % 3;
            end
          end
        end else if (phase[c] == 1) begin
          chk(disp_valid[c] && int'(disp_task[c*TW +: TW]) == ctask[c] &&
              int'(disp_inst[c*CW +: CW]) == cinst[c], "R6 offer held",
              int'(disp_inst[c*CW +: CW]), cinst[c]);
          cnt[c]--;
          if (cnt[c] == 0) begin
            disp_ready[c] = 1'b1;
            phase[c] = 2;
            cnt[c] = 1 + (cinst[c] + c) % 4;
          end
        end else if (phase[c] == 2) begin
          disp_ready[c] = 1'b0;
          chk(cpl_ready[c] == 1'b1 && disp_valid[c] == 1'b0, "R9 busy accepts", int'(cpl_ready[c]), 1);
          cnt[c]--;
          if (cnt[c] == 0) begin
            cpl_valid[c] = 1'b1;
            cpl_result[c] = (scen == 2 && ctask[c] == 2) ? (cpl_count[2] >= 2) : 1'b1;
            phase[c] = 3;
          end
        end else begin
          cpl_valid[c] = 1'b0;
          cpl_result[c] = 1'b0;
          chk(cpl_ready[c] == 1'b0, "R9 idle after completion", int'(cpl_ready[c]), 0);
          cpl_count[ctask[c]]++;
          phase[c] = 0;
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    model_on = 0;
    sched_en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int t = 0; t < NT; t++) begin
      disp_count[t] = 0;
      cpl_count[t] = 0;
    end
    for (int i = 0; i < 128; i++) seen[i] = 0;
    rec_n = 0;
    @(negedge clk);
    chk(disp_valid == '0, "R1 no offer", int'(disp_valid), 0);
    chk(task_done == '0, "R1 done clear", int'(task_done), 0);
    chk(cpl_ready == '0, "R1 no busy", int'(cpl_ready), 0);
    model_on = 1;
  endtask

  task automatic load(input int id, input int pred, input int lp, input bit dup, input int count);
    cfg_we = 1'b1;
    cfg_task = TW'(id);
    cfg_pred = NT'(pred);
    cfg_loop = NT'(lp);
    cfg_dup = dup;
    cfg_count = CW'(count);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(input int exp, input string req);
    int k;
    k = 0;
    while (int'(task_done) != exp && k < 20000) begin
      @(negedge clk);
      k++;
    end
    repeat (4) @(negedge clk);
    chk(int'(task_done) == exp, req, int'(task_done), exp);
  endtask

  initial begin
    // Scenario 1: start -> 100 replicated -> end
    scen = 1;
    do_reset();
    load(0, 0, 0, 1'b0, 9);
    load(1, 16'h0001, 0, 1'b1, 100);
    load(2, 16'h0002, 0, 1'b0, 1);
    sched_en = 1;
    wait_done(16'h0007, "R10 fork/join done vector");
    chk(disp_count[0] == 1, "R2 single-shot runs once", disp_count[0], 1);
    chk(disp_count[1] == 100, "R5 instance total", disp_count[1], 100);
    chk(disp_count[2] == 1, "R7 end runs once", disp_count[2], 1);
    for (int i = 0; i < 100; i++) chk(seen[i] == 1, "R5 instance once", seen[i], 1);

    // Scenario 2: loop of three rounds driven by controller result
    scen = 2;
    do_reset();
    load(0, 0, 0, 1'b0, 1);
    load(1, 16'h0001, 0, 1'b1, 5);
    load(2, 16'h0002, 16'h0002, 1'b0, 1);
    load(3, 16'h0004, 0, 1'b0, 1);
    sched_en = 1;
    wait_done(16'h000F, "R10 loop done vector");
    chk(disp_count[1] == 15, "R8 body re-run count", disp_count[1], 15);
    chk(disp_count[2] == 3, "R8 controller runs", disp_count[2], 3);
    chk(disp_count[3] == 1, "R8 exit once", disp_count[3], 1);
    for (int i = 0; i < 5; i++) chk(seen[i] == 3, "R8 instance per round", seen[i], 3);

    // Scenario 3: enable gating and same-cycle multi-core priority
    scen = 3;
    do_reset();
    load(2, 0, 0, 1'b1, 4);
    load(1, 0, 0, 1'b1, 4);
    repeat (4) @(negedge clk);
    chk(disp_valid == '0 && rec_n == 0, "R3 nothing while disabled", int'(disp_valid), 0);
    sched_en = 1;
    wait_done(16'h0006, "R10 two roots done");
    chk(rec_n == 8, "R4 dispatch total", rec_n, 8);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule